// File: doc/BRIEF.md
# Serial EEPROM Write Controller (Two-Wire Slave)

This block is the write side of a small serial EEPROM that answers as a slave on a two-wire I2C bus. It watches already-synchronised SCL and SDA lines, recognises start and stop conditions, and checks the control byte against a fixed device code. It then takes a word address and one or more data bytes. Each accepted byte is acknowledged by pulling SDA low through an open-drain enable.

Data bytes go into an eight-entry page buffer indexed by the low three bits of the address pointer, so a long burst wraps inside its page. A stop condition then starts a self-timed programming cycle that copies the buffered bytes into a behavioural byte array. The cycle length is a parameter. While it runs the block ignores the bus entirely. A separate write-enable input must stay high from start to stop, or nothing is programmed. A combinational inspection port lets a bench read any byte of the array.

Top module: `eew_wr_top`

## Requirements
- R1: A control byte of 8'hA0 (device code 4'b1010 in bits 7:4, zeros in bits 3:1, write flag bit 0 = 0) is acknowledged. Any other value is not acknowledged, and no byte after it is acknowledged until the next start condition.
- R2: An acknowledge (sda_oe_o = 1) begins only after the SCL falling edge that ends bit eight of a byte. It ends once the ninth SCL clock has fallen.
- R3: The byte after an acknowledged control byte is acknowledged and becomes the full address pointer.
- R4: One data byte followed by a stop condition writes that byte at the pointer address.
- R5: Data byte i of a burst lands at address {upper five pointer bits, (low three bits + i) mod 8}. The upper bits never change, and every data byte is acknowledged.
- R6: When more than eight data bytes arrive, a later byte replaces the earlier byte in the same slot.
- R7: A stop condition after at least one data byte raises busy_o for exactly WR_CYCLES clocks. The array changes only on the clock where busy_o falls.
- R8: While busy_o is high, no byte is acknowledged, including a correct control byte.
- R9: If wen_i is low at any time between the start condition and the stop condition, nothing is programmed and busy_o stays low.
- R10: Changes on wen_i after busy_o has risen do not stop or alter the programming.
- R11: A repeated start discards every data byte buffered since the previous start.
- R12: A stop condition that arrives before any data byte does not raise busy_o and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data (bus level) |
| wen_i | input | 1 | Programming enable; high for the whole transfer |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) when 1 |
| busy_o | output | 1 | Self-timed programming in progress |
| peek_addr_i | input | ADDR_W | Inspection address into the byte array |
| peek_data_o | output | 8 | Array byte at peek_addr_i |

## Verification
Every one of the 256 control byte values is sent after a start. This separates the single accepted code from neighbours that differ in the device code, in the middle zeros or in the direction bit, and it shows that a refused byte leaves the slave deaf. Page writes are swept over all eight starting offsets and burst lengths from one to eleven. Short bursts, bursts that wrap past slot seven and bursts that overwrite a slot each leave a different footprint, and the bench compares the whole array against its own arithmetic model. Separate sequences cover disturbances: wen_i dropped during a transfer or during busy, a control byte sent while busy, a repeated start, and a stop before any data.

// File: rtl/eew_pkg.sv
package eew_pkg;
    // Position of the transfer within one start..stop frame
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CTRL,
        PH_ADDR,
        PH_DATA
    } phase_t;
endpackage

// File: rtl/eew_cond_det.sv
// Bus event detector.
// Registers SCL/SDA once and reports SCL edges plus start (SDA falls with
// SCL high) and stop (SDA rises with SCL high) conditions as one-cycle
// pulses. Assumes the inputs are already synchronised to clk.
module eew_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic scl_q;
    logic sda_q;

    // Keep the previous bus levels; both lines idle high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Edge and condition decode against the registered levels
    always_comb begin
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
        start_o    = scl_i & scl_q & sda_q & ~sda_i;
        stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/eew_proto_fsm.sv
// Byte-level protocol engine.
// Counts SCL rises per byte, shifts SDA in, decides the acknowledge after
// the eighth bit, keeps the address pointer and tracks the write enable.
// Emits buffer writes per data byte and a commit pulse on a valid stop.
// Assumes the bench/master changes SDA only while SCL is low, except
// when it signals a start or a stop.
module eew_proto_fsm
    import eew_pkg::*;
#(
    parameter int         ADDR_W     = 8,
    parameter int         PAGE_BITS  = 3,
    parameter logic [3:0] SLAVE_CODE = 4'b1010
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        stop_i,
    input  logic                        scl_rise_i,
    input  logic                        scl_fall_i,
    input  logic                        sda_i,
    input  logic                        wen_i,
    input  logic                        busy_i,
    output logic                        ack_o,
    output logic                        buf_we_o,
    output logic [PAGE_BITS-1:0]        buf_idx_o,
    output logic [7:0]                  buf_data_o,
    output logic                        buf_clr_o,
    output logic                        commit_o,
    output logic [ADDR_W-PAGE_BITS-1:0] page_base_o
);
    localparam logic [3:0] BIT_LAST = 4'd8;
    localparam logic [3:0] BIT_ACK  = 4'd9;

    phase_t             phase;
    logic [3:0]         bitcnt;
    logic [7:0]         shreg;
    logic               ack_q;
    logic [ADDR_W-1:0]  ptr;
    logic               wen_ok;
    logic               have_data;
    logic               ctrl_ok;
    logic               byte_end;

    // Control byte acceptance: code, zero field, write direction, idle engine
    always_comb begin
        ctrl_ok  = (shreg[7:4] == SLAVE_CODE) && (shreg[3:1] == 3'b000)
                   && !shreg[0] && !busy_i;
        byte_end = scl_fall_i && (phase != PH_IDLE) && (bitcnt == BIT_LAST)
                   && !start_i && !stop_i;
    end

    // Frame sequencing, bit shifting, acknowledge and pointer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            ack_q     <= 1'b0;
            ptr       <= '0;
            wen_ok    <= 1'b0;
            have_data <= 1'b0;
        end else if (start_i) begin
            phase     <= PH_CTRL;
            bitcnt    <= '0;
            ack_q     <= 1'b0;
            wen_ok    <= wen_i;
            have_data <= 1'b0;
        end else if (stop_i) begin
            phase     <= PH_IDLE;
            bitcnt    <= '0;
            ack_q     <= 1'b0;
            have_data <= 1'b0;
        end else begin
            if (phase != PH_IDLE && !wen_i) begin
                wen_ok <= 1'b0;
            end
            if (scl_rise_i && phase != PH_IDLE && bitcnt < BIT_ACK) begin
                if (bitcnt < BIT_LAST) begin
                    shreg <= {shreg[6:0], sda_i};
                end
                bitcnt <= bitcnt + 4'd1;
            end
            if (byte_end) begin
                unique case (phase)
                    PH_CTRL: begin
                        if (ctrl_ok) begin
                            ack_q <= 1'b1;
                        end else begin
                            phase  <= PH_IDLE;
                            bitcnt <= '0;
                        end
                    end
                    PH_ADDR: begin
                        ack_q <= 1'b1;
                        ptr   <= shreg;
                    end
                    PH_DATA: begin
                        ack_q     <= 1'b1;
                        have_data <= 1'b1;
                        ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + 1'b1;
                    end
                    default: ;
                endcase
            end else if (scl_fall_i && phase != PH_IDLE && bitcnt == BIT_ACK) begin
                bitcnt <= '0;
                ack_q  <= 1'b0;
                if (phase == PH_CTRL) begin
                    phase <= PH_ADDR;
                end else if (phase == PH_ADDR) begin
                    phase <= PH_DATA;
                end
            end
        end
    end

    // Buffer and commit strobes derived from the current frame state
    always_comb begin
        ack_o       = ack_q;
        buf_we_o    = byte_end && (phase == PH_DATA);
        buf_idx_o   = ptr[PAGE_BITS-1:0];
        buf_data_o  = shreg;
        buf_clr_o   = start_i && !busy_i;
        commit_o    = stop_i && (phase == PH_DATA) && have_data
                      && wen_ok && wen_i && !busy_i;
        page_base_o = ptr[ADDR_W-1:PAGE_BITS];
    end
endmodule

// File: rtl/eew_page_buf.sv
// Page buffer: one byte and one valid flag per slot of the page.
// A slot write overwrites whatever the slot held; clear drops all flags.
// Assumes clear and write never coincide.
module eew_page_buf #(
    parameter int PAGE_BITS = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          we_i,
    input  logic [PAGE_BITS-1:0]          idx_i,
    input  logic [7:0]                    data_i,
    output logic [(1<<PAGE_BITS)-1:0][7:0] slot_data_o,
    output logic [(1<<PAGE_BITS)-1:0]     slot_valid_o
);
    localparam int SLOTS = 1 << PAGE_BITS;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Hold one buffered byte and its valid flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_data_o[s]  <= '0;
                slot_valid_o[s] <= 1'b0;
            end else if (clr_i) begin
                slot_valid_o[s] <= 1'b0;
            end else if (we_i && idx_i == PAGE_BITS'(s)) begin
                slot_data_o[s]  <= data_i;
                slot_valid_o[s] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/eew_array_wr.sv
// Behavioural byte array with a self-timed programming engine.
// A commit latches the page number and runs for WR_CYCLES clocks. On the
// last clock every valid buffer slot is copied into the array. Nothing
// outside the commit pulse affects the engine once it has started.
module eew_array_wr #(
    parameter int ADDR_W    = 8,
    parameter int PAGE_BITS = 3,
    parameter int WR_CYCLES = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           commit_i,
    input  logic [ADDR_W-PAGE_BITS-1:0]    page_base_i,
    input  logic [(1<<PAGE_BITS)-1:0][7:0] slot_data_i,
    input  logic [(1<<PAGE_BITS)-1:0]      slot_valid_i,
    input  logic [ADDR_W-1:0]              peek_addr_i,
    output logic                           busy_o,
    output logic                           done_o,
    output logic [7:0]                     peek_data_o
);
    localparam int SLOTS = 1 << PAGE_BITS;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_CYCLES - 1);

    logic [7:0]                  mem [DEPTH];
    logic [CNT_W-1:0]            cnt;
    logic [ADDR_W-PAGE_BITS-1:0] base_q;

    // Last clock of the programming window
    always_comb begin
        done_o = busy_o && (cnt == CNT_LAST);
    end

    // Programming timer and page latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt    <= '0;
            base_q <= '0;
        end else if (!busy_o) begin
            if (commit_i) begin
                busy_o <= 1'b1;
                cnt    <= '0;
                base_q <= page_base_i;
            end
        end else if (done_o) begin
            busy_o <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Array storage: erased at reset, page copied at the end of programming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) begin
                mem[a] <= 8'hFF;
            end
        end else if (done_o) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (slot_valid_i[s]) begin
                    mem[{base_q, s[PAGE_BITS-1:0]}] <= slot_data_i[s];
                end
            end
        end
    end

    assign peek_data_o = mem[peek_addr_i];
endmodule

// File: rtl/eew_wr_top.sv
// Write controller top: bus event detector, protocol engine, page buffer
// and self-timed array. Assumes synchronised SCL/SDA and an external
// open-drain driver controlled by sda_oe_o.
module eew_wr_top #(
    parameter int         ADDR_W     = 8,
    parameter int         PAGE_BITS  = 3,
    parameter int         WR_CYCLES  = 64,
    parameter logic [3:0] SLAVE_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              wen_i,
    output logic              sda_oe_o,
    output logic              busy_o,
    input  logic [ADDR_W-1:0] peek_addr_i,
    output logic [7:0]        peek_data_o
);
    localparam int SLOTS = 1 << PAGE_BITS;

    logic start, stop, scl_rise, scl_fall;
    logic buf_we, buf_clr, commit, wr_done;
    logic [PAGE_BITS-1:0]        buf_idx;
    logic [7:0]                  buf_data;
    logic [ADDR_W-PAGE_BITS-1:0] page_base;
    logic [SLOTS-1:0][7:0]       slot_data;
    logic [SLOTS-1:0]            slot_valid;

    eew_cond_det u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .start_o    (start),
        .stop_o     (stop),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall)
    );

    eew_proto_fsm #(
        .ADDR_W     (ADDR_W),
        .PAGE_BITS  (PAGE_BITS),
        .SLAVE_CODE (SLAVE_CODE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .stop_i      (stop),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .sda_i       (sda_i),
        .wen_i       (wen_i),
        .busy_i      (busy_o),
        .ack_o       (sda_oe_o),
        .buf_we_o    (buf_we),
        .buf_idx_o   (buf_idx),
        .buf_data_o  (buf_data),
        .buf_clr_o   (buf_clr),
        .commit_o    (commit),
        .page_base_o (page_base)
    );

    eew_page_buf #(
        .PAGE_BITS (PAGE_BITS)
    ) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (buf_clr | wr_done),
        .we_i         (buf_we),
        .idx_i        (buf_idx),
        .data_i       (buf_data),
        .slot_data_o  (slot_data),
        .slot_valid_o (slot_valid)
    );

    eew_array_wr #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS),
        .WR_CYCLES (WR_CYCLES)
    ) u_arr (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_i     (commit),
        .page_base_i  (page_base),
        .slot_data_i  (slot_data),
        .slot_valid_i (slot_valid),
        .peek_addr_i  (peek_addr_i),
        .busy_o       (busy_o),
        .done_o       (wr_done),
        .peek_data_o  (peek_data_o)
    );
endmodule

// File: rtl/eew_wr_checker.sv
// Port-level protocol checks for eew_wr_top, attached by bind.
module eew_wr_checker #(
    parameter int ADDR_W    = 8,
    parameter int WR_CYCLES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_i,
    input logic              sda_oe_o,
    input logic              busy_o,
    input logic [ADDR_W-1:0] peek_addr_i,
    input logic [7:0]        peek_data_o
);
    localparam int CW = $clog2(WR_CYCLES + 2);
    logic [CW-1:0] busy_len;

    // Count consecutive busy clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len <= '0;
        end else if (busy_o) begin
            busy_len <= busy_len + 1'b1;
        end else begin
            busy_len <= '0;
        end
    end

    assert_ack_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> (!$past(scl_i) && $past(scl_i, 2)));

    assert_no_ack_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_oe_o);

    assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_len == CW'(WR_CYCLES)));

    assert_busy_from_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(scl_i) && $past(sda_i) && !$past(sda_i, 2)));

    assert_mem_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o) && $stable(peek_addr_i)) |-> $stable(peek_data_o));
endmodule

bind eew_wr_top eew_wr_checker #(
    .ADDR_W    (ADDR_W),
    .WR_CYCLES (WR_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .sda_oe_o    (sda_oe_o),
    .busy_o      (busy_o),
    .peek_addr_i (peek_addr_i),
    .peek_data_o (peek_data_o)
);

// File: tb/test_eew_wr_top.sv
module test_eew_wr_top;
    localparam int WR = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic       wen = 1'b1;
    logic [7:0] peek_addr = '0;
    logic       sda_oe, busy;
    logic [7:0] peek_data;
    logic       sda_bus;
    logic [7:0] expm [256];
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;
    assign sda_bus = sda_drv & ~sda_oe;

    eew_wr_top #(.WR_CYCLES(WR)) i_eew_wr_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .wen_i       (wen),
        .sda_oe_o    (sda_oe),
        .busy_o      (busy),
        .peek_addr_i (peek_addr),
        .peek_data_o (peek_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; hold(1);
        scl = 1'b1;     hold(2);
        sda_drv = 1'b0; hold(2);
        scl = 1'b0;     hold(1);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; hold(1);
        scl = 1'b1;     hold(2);
        sda_drv = 1'b1; hold(2);
    endtask

    // Send one byte MSB first and return whether it was acknowledged (R2 timing checked)
    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; hold(1);
            scl = 1'b1;     hold(2);
            if (i == 0) chk("R2 no ack before eighth fall", sda_oe, 0);
            scl = 1'b0;     hold(1);
        end
        sda_drv = 1'b1; hold(1);
        scl = 1'b1;     hold(1);
        acked = sda_oe;
        hold(1);
        scl = 1'b0;     hold(1);
        chk("R2 ack released after ninth fall", sda_oe, 0);
    endtask

    function automatic logic [7:0] dbyte(input logic [7:0] seed, input int i);
        return seed + 8'(i * 13);
    endfunction

    // Full write transaction: control, address, n data bytes, stop
    task automatic do_write(input logic [7:0] addr, input int n, input logic [7:0] seed);
        bit a;
        bus_start();
        send_byte(8'hA0, a); chk("R1 write control acked", a, 1);
        send_byte(addr, a);  chk("R3 address acked", a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(dbyte(seed, i), a);
            chk("R5 data byte acked", a, 1);
        end
        bus_stop();
    endtask

    task automatic model_page(input logic [7:0] addr, input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            expm[{addr[7:3], 3'(addr[2:0] + 3'(i))}] = dbyte(seed, i);
        end
    endtask

    task automatic wait_idle();
        int c = 0;
        while (busy && c < 1000) begin hold(1); c++; end
        chk("R7 programming ends within window", (c <= WR) ? 1 : 0, 1);
        hold(2);
    endtask

    task automatic check_mem(input string req);
        for (int a = 0; a < 256; a++) begin
            peek_addr = 8'(a); hold(1);
            chk(req, peek_data, expm[a]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit a;
        for (int i = 0; i < 256; i++) expm[i] = 8'hFF;
        hold(4);
        rst_n = 1'b1;
        hold(2);

        // Reset state
        chk("R7 reset sda_oe low", sda_oe, 0);
        chk("R7 reset busy low", busy, 0);
        check_mem("R7 reset array erased");

        // R1: sweep every control byte value; R12: A0 then stop writes nothing
        for (int c = 0; c < 256; c++) begin
            bus_start();
            send_byte(8'(c), a);
            chk("R1 control byte decode", a, (c == 8'hA0) ? 1 : 0);
            if (c != 8'hA0) begin
                send_byte(8'hA0, a);
                chk("R1 refused slave stays idle", a, 0);
            end
            bus_stop();
            hold(2);
            chk("R12 no data no busy", busy, 0);
        end

        // R12: control + address then stop
        bus_start();
        send_byte(8'hA0, a); send_byte(8'h42, a);
        chk("R3 address acked", a, 1);
        bus_stop(); hold(2);
        chk("R12 address only no busy", busy, 0);
        check_mem("R12 array unchanged");

        // R4: byte writes at scattered addresses
        for (int k = 0; k < 8; k++) begin
            logic [7:0] ad = 8'(k * 37 + 5);
            do_write(ad, 1, 8'(k ^ 8'h5A));
            chk("R7 busy after stop", busy, 1);
            model_page(ad, 1, 8'(k ^ 8'h5A));
            wait_idle();
        end
        check_mem("R4 byte write contents");

        // R5/R6: page sweep over offsets and lengths 1..11
        for (int off = 0; off < 8; off++) begin
            for (int len = 1; len <= 11; len++) begin
                logic [7:0] ad = {5'((off * 11 + len * 3) % 32), 3'(off)};
                do_write(ad, len, 8'(off * 16 + len));
                model_page(ad, len, 8'(off * 16 + len));
                wait_idle();
                check_mem((len > 8) ? "R6 overwrite on wrap" : "R5 page wrap placement");
            end
        end

        // R8: correct control byte refused while busy
        do_write(8'h10, 2, 8'h31);
        model_page(8'h10, 2, 8'h31);
        bus_start();
        send_byte(8'hA0, a);
        chk("R8 no ack while busy", a, 0);
        send_byte(8'h10, a);
        chk("R8 no ack while busy", a, 0);
        bus_stop();
        wait_idle();
        check_mem("R8 busy refusal keeps first write");

        // R9: wen low for whole transfer
        wen = 1'b0;
        do_write(8'h20, 3, 8'h77);
        hold(2);
        chk("R9 wen low no busy", busy, 0);
        wen = 1'b1;
        // R9: wen dropped briefly mid-data
        bus_start();
        send_byte(8'hA0, a); send_byte(8'h28, a);
        wen = 1'b0; send_byte(8'h99, a); wen = 1'b1;
        send_byte(8'h98, a);
        bus_stop(); hold(2);
        chk("R9 wen glitch no busy", busy, 0);
        check_mem("R9 array unchanged");

        // R10: wen dropped during programming
        do_write(8'h30, 4, 8'hC3);
        model_page(8'h30, 4, 8'hC3);
        hold(3);
        wen = 1'b0;
        hold(5);
        chk("R10 busy holds with wen low", busy, 1);
        wait_idle();
        wen = 1'b1;
        check_mem("R10 write completes");

        // R11: repeated start discards; then stop without data writes nothing
        bus_start();
        send_byte(8'hA0, a); send_byte(8'h40, a);
        send_byte(8'h11, a); send_byte(8'h12, a);
        bus_start();
        bus_stop(); hold(2);
        chk("R11 discarded no busy", busy, 0);
        // R11: repeated start then a fresh single byte; only it is written
        bus_start();
        send_byte(8'hA0, a); send_byte(8'h48, a);
        send_byte(8'h21, a); send_byte(8'h22, a); send_byte(8'h23, a);
        bus_start();
        send_byte(8'hA0, a); send_byte(8'h4D, a);
        send_byte(8'hE7, a);
        bus_stop();
        expm[8'h4D] = 8'hE7;
        wait_idle();
        check_mem("R11 only post-restart byte written");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule